// File: doc/BRIEF.md
# Slow Tick Divider with Tap-Selectable Interrupts

This block divides a low-speed clock of about 32.768 kHz down to a ladder of eight binary taps. The taps run from 128 Hz (bit 0) down to 1 Hz (bit 7). A prescaler of `PRESCALE_W` bits sits below the lowest tap. The counter advances on each falling edge of the slow clock. Its tap bits are presented on a read port straight from the slow-clock registers, with no resynchronisation. Software therefore reads the port twice and accepts the value only when both reads agree.

A one-cycle write strobe in the CPU clock domain clears the prescaler and every tap. Three interrupt channels each choose one tap through a 3-bit select field. The tap bits are resynchronised into the CPU clock by two flops. Each channel then runs a small state machine with three states. In TAP_LOW the channel waits for its tap to be 1; the transition tap=1 leads to TAP_HIGH. TAP_HIGH holds while the tap stays 1; the transition tap=0 leads to EDGE_SEEN. EDGE_SEEN lasts exactly one cycle and leaves to TAP_HIGH if tap=1, otherwise to TAP_LOW. The cycle spent in EDGE_SEEN sets the channel's request flag at the following edge. A clear of the counter while the selected tap is 1 is a real 1-to-0 fall, so it raises that channel's flag.

Top module: `slow_tick_timer`

## Requirements
- R1: After reset, `tap_val`, `irq_flag` and `irq_req` are all zero.
- R2: Each falling edge of `lsclk` increments a counter of PRESCALE_W+8 bits that wraps to zero. `tap_val` equals the counter shifted right by PRESCALE_W, with bit 0 the fastest tap and bit 7 the slowest.
- R3: `wr_en` high at a rising `clk` edge clears the prescaler and all taps to zero by the next `clk` edge. Counting then resumes from zero on later `lsclk` falls.
- R4: Channel i uses field `tap_sel[3*i+2:3*i]` as a tap index, where 0 is the fastest tap and 7 the slowest. Its flag is set when that tap falls from 1 to 0.
- R5: A counter clear while a channel's selected tap is 1 sets that channel's flag. A channel whose selected tap is 0 at the clear is not flagged.
- R6: If `wr_en` is sampled high at clk edge k and the selected tap was 1, the flag is still 0 after edge k+3 and is 1 after edge k+4. Edge k+3 is the detection edge, where EDGE_SEEN is entered.
- R7: `irq_req[i]` is high exactly when `irq_flag[i]` and `irq_en[i]` are both high. Flags are set whether or not the channel is enabled.
- R8: `irq_clr[i]` high at a clk edge clears `irq_flag[i]` at that edge unless a set happens in the same cycle.
- R9: When a set and a clear of a flag fall on the same edge, the flag ends set. A clear issued in the cycle right after the counter write is followed by the delayed set, so the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lsclk | input | 1 | Low-speed clock; the counter advances on its falling edge |
| wr_en | input | 1 | Write strobe to the counter; clears the divider |
| tap_sel | input | 9 | Three 3-bit tap indices, channel 0 in bits 2:0 |
| irq_en | input | 3 | Per-channel interrupt enable |
| irq_clr | input | 3 | Per-channel request clear strobe |
| tap_val | output | 8 | Raw tap bits, 128 Hz in bit 0 |
| irq_flag | output | 3 | Per-channel request flag |
| irq_req | output | 3 | Enabled requests (flag AND enable) |

## Verification
The delayed flag set that follows a counter write can land on the same CPU clock edge as a software clear of that flag. The bench places the tap of channel 0 at 1 and issues a write. It then raises `irq_clr` exactly in the cycle that ends at edge k+4, so set and clear coincide, and the flag must read 1 afterwards. A second run clears one cycle after the write; here the later set must again leave the flag at 1, while a clear in a quiet cycle must drop it to 0.

// File: rtl/stt_pkg.sv
package stt_pkg;
    typedef enum logic [1:0] {
        TAP_LOW   = 2'd0,
        TAP_HIGH  = 2'd1,
        EDGE_SEEN = 2'd2
    } edge_st_e;

    localparam int TAPS   = 8;
    localparam int CHANS  = 3;
    localparam int SEL_W  = $clog2(TAPS);
endpackage

// File: rtl/stt_divider.sv
module stt_divider #(
    parameter int PRESCALE_W = 8,
    parameter int TAP_W      = 8
) (
    input  logic             lsclk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [TAP_W-1:0] taps
);
    localparam int CNT_W = PRESCALE_W + TAP_W;

    logic [CNT_W-1:0] cnt_q;

    // Counter advances on the slow clock's falling edge; clear is asynchronous
    always_ff @(negedge lsclk or negedge rst_n or posedge clr) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign taps = cnt_q[CNT_W-1:PRESCALE_W];
endmodule

// File: rtl/stt_sync.sv
module stt_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/stt_chan.sv
module stt_chan
    import stt_pkg::*;
#(
    parameter int TAP_W = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] taps_s,
    input  logic [IDX_W-1:0] sel,
    input  logic             en,
    input  logic             clr,
    output logic             flag,
    output logic             req
);
    edge_st_e state_q, state_d;
    logic     tap_bit;
    logic     flag_q;

    assign tap_bit = taps_s[sel];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TAP_LOW:   state_d = tap_bit ? TAP_HIGH : TAP_LOW;
            TAP_HIGH:  state_d = tap_bit ? TAP_HIGH : EDGE_SEEN;
            EDGE_SEEN: state_d = tap_bit ? TAP_HIGH : TAP_LOW;
            default:   state_d = TAP_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TAP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: delayed flag set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (state_q == EDGE_SEEN) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        flag = flag_q;
        req  = flag_q & en;
    end

    // R4: a flag only rises after the selected tap was seen low
    p_rise_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> !$past(tap_bit));

    // R6: the detection state lasts one cycle
    p_edge_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDGE_SEEN) |=> (state_q != EDGE_SEEN));

    // R9: a detected edge always leaves the flag set, clear or not
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDGE_SEEN) |=> flag_q);

    // R8: a clear in a quiet cycle drops the flag
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && state_q != EDGE_SEEN) |=> !flag_q);
endmodule

// File: rtl/slow_tick_timer.sv
module slow_tick_timer
    import stt_pkg::*;
#(
    parameter int PRESCALE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lsclk,
    input  logic                   wr_en,
    input  logic [CHANS*SEL_W-1:0] tap_sel,
    input  logic [CHANS-1:0]       irq_en,
    input  logic [CHANS-1:0]       irq_clr,
    output logic [TAPS-1:0]        tap_val,
    output logic [CHANS-1:0]       irq_flag,
    output logic [CHANS-1:0]       irq_req
);
    logic            clr_q;
    logic [TAPS-1:0] taps_raw;
    logic [TAPS-1:0] taps_s;

    // Registered write strobe drives the divider's asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= wr_en;
        end
    end

    stt_divider #(
        .PRESCALE_W (PRESCALE_W),
        .TAP_W      (TAPS)
    ) u_div (
        .lsclk (lsclk),
        .rst_n (rst_n),
        .clr   (clr_q),
        .taps  (taps_raw)
    );

    assign tap_val = taps_raw;

    stt_sync #(
        .W (TAPS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (taps_raw),
        .q     (taps_s)
    );

    for (genvar i = 0; i < CHANS; i++) begin : g_chan
        stt_chan #(
            .TAP_W (TAPS),
            .IDX_W (SEL_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .taps_s (taps_s),
            .sel    (tap_sel[i*SEL_W +: SEL_W]),
            .en     (irq_en[i]),
            .clr    (irq_clr[i]),
            .flag   (irq_flag[i]),
            .req    (irq_req[i])
        );
    end

    // R3: while the clear strobe is held, every tap reads zero
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> (tap_val == '0));
endmodule

// File: tb/slow_tick_timer_bench.sv
module slow_tick_timer_bench;
    localparam int PW   = 2;
    localparam int CW   = PW + 8;
    localparam int MODV = 1 << CW;
    localparam int NROW = 8;
    localparam int ROW_TICKS [NROW] = '{1, 3, 4, 24, 68, 412, 508, 4};
    localparam logic [7:0] ROW_TAP [NROW] = '{8'd0, 8'd1, 8'd2, 8'd8,
                                              8'd25, 8'd128, 8'd255, 8'd0};
    localparam int SEL0 = 0, SEL1 = 2, SEL2 = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lsclk = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] tap_sel = {3'(SEL2), 3'(SEL1), 3'(SEL0)};
    logic [2:0] irq_en = 3'b101;
    logic [2:0] irq_clr = 3'b000;
    logic [7:0] tap_val;
    logic [2:0] irq_flag;
    logic [2:0] irq_req;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    logic [2:0] exp_flag = 3'b000;
    int sels [3] = '{SEL0, SEL1, SEL2};

    always #2 clk = ~clk;

    slow_tick_timer #(.PRESCALE_W(PW)) u_slow_tick_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .lsclk    (lsclk),
        .wr_en    (wr_en),
        .tap_sel  (tap_sel),
        .irq_en   (irq_en),
        .irq_clr  (irq_clr),
        .tap_val  (tap_val),
        .irq_flag (irq_flag),
        .irq_req  (irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic tapbit(input int c, input int s);
        return 1'((c >> (PW + s)) & 1);
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick();
        int old;
        @(negedge clk);
        lsclk = 1'b0;
        old = cnt;
        cnt = (cnt + 1) % MODV;
        for (int ch = 0; ch < 3; ch++)
            if (tapbit(old, sels[ch]) && !tapbit(cnt, sels[ch])) exp_flag[ch] = 1'b1;
        cyc(5);
        lsclk = 1'b1;
        cyc(5);
    endtask

    task automatic write_clear();
        @(negedge clk);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        for (int ch = 0; ch < 3; ch++)
            if (tapbit(cnt, sels[ch])) exp_flag[ch] = 1'b1;
        cnt = 0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        irq_clr = 3'b111;
        @(negedge clk);
        irq_clr = 3'b000;
        exp_flag = 3'b000;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        cyc(3);
        chk("R1 tap_val", 32'(tap_val), 0);
        chk("R1 irq_flag", 32'(irq_flag), 0);
        chk("R1 irq_req", 32'(irq_req), 0);
        rst_n = 1'b1;
        cyc(3);

        // Table walk: ticks per row, expected taps and flags (R2, R4, R7)
        for (int r = 0; r < NROW; r++) begin
            for (int t = 0; t < ROW_TICKS[r]; t++) tick();
            cyc(2);
            chk("R2 tap_val row", 32'(tap_val), 32'(ROW_TAP[r]));
            chk("R4 flags row", 32'(irq_flag), 32'(exp_flag));
            chk("R7 req row", 32'(irq_req), 32'(exp_flag & irq_en));
        end

        // R8: clear all flags
        clear_all();
        cyc(1);
        chk("R8 cleared", 32'(irq_flag), 0);

        // R3, R5: clear with tap 0 high, tap 2 and tap 7 low
        for (int t = 0; t < 4; t++) tick();
        cyc(4);
        chk("R2 tap after 4", 32'(tap_val), 1);
        write_clear();
        chk("R3 tap zero", 32'(tap_val), 0);
        cyc(6);
        chk("R5 spurious flag", 32'(irq_flag), 3'b001);
        chk("R7 req masked", 32'(irq_req), 3'b001);
        irq_en = 3'b000;
        cyc(1);
        chk("R7 req disabled", 32'(irq_req), 0);
        irq_en = 3'b101;
        for (int t = 0; t < 3; t++) tick();
        chk("R3 resume zero", 32'(tap_val), 0);
        tick();
        chk("R3 resume one", 32'(tap_val), 1);
        cyc(4);

        // R6: exact flag timing after a write
        clear_all();
        cyc(2);
        @(negedge clk);
        wr_en = 1'b1;          // sampled at edge k
        @(negedge clk);
        wr_en = 1'b0;          // after k
        cnt = 0;
        cyc(3);                // after k+3
        chk("R6 flag low at k+3", 32'(irq_flag[0]), 0);
        cyc(1);                // after k+4
        chk("R6 flag high at k+4", 32'(irq_flag[0]), 1);

        // R9: clear coinciding with the set at k+4
        for (int t = 0; t < 4; t++) tick();
        cyc(4);
        clear_all();
        cyc(1);
        chk("R8 pre-clear", 32'(irq_flag), 0);
        @(negedge clk);
        wr_en = 1'b1;          // edge k
        @(negedge clk);
        wr_en = 1'b0;
        cnt = 0;
        cyc(3);                // after k+3
        irq_clr = 3'b001;      // sampled at k+4
        @(negedge clk);
        irq_clr = 3'b000;
        cyc(2);
        chk("R9 set wins", 32'(irq_flag[0]), 1);

        // R9: clear one cycle after the write is followed by the set
        for (int t = 0; t < 4; t++) tick();
        cyc(4);
        clear_all();
        @(negedge clk);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        irq_clr = 3'b001;
        @(negedge clk);
        irq_clr = 3'b000;
        cyc(6);
        chk("R9 late set kept", 32'(irq_flag[0]), 1);

        // R8: quiet clear
        @(negedge clk);
        irq_clr = 3'b001;
        @(negedge clk);
        irq_clr = 3'b000;
        chk("R8 quiet clear", 32'(irq_flag[0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule